// File: doc/BRIEF.md
# Accumulator-based 8-bit microcontroller core

This block is a small 8-bit processor built around one accumulator. It fetches 12-bit instruction words from an external 256-word program ROM, addressed by an 8-bit program counter, and runs a reduced instruction set. That set covers moves between the accumulator and a 32-entry file address space, increment, add, AND, nibble swap, clears, literal loads, jumps, a call that returns with a literal in the accumulator, and conditional skips on a single bit. File operations carry a destination bit that sends the result either to the accumulator or back to the file register.

The file address space holds three general-purpose I/O ports and 24 general registers. Each port has a direction register that is loaded from the accumulator. The core drives a data value and an output-enable per pin, so that a pad ring or a tristate buffer outside the block can use them. Fetch and execute overlap: while one word executes, the next is being fetched. Jumps, calls, returns and taken skips discard that prefetched word, so each of them costs one extra cycle.

Top module: `mcu8_core`

## Requirements
- R1: After reset is released, the program address starts at 0 and advances by one each cycle. Executing a jump, call or return loads the program address from the instruction instead, and the word already fetched is discarded.
- R2: While reset is active, the accumulator, program counter and port latches are zero and every direction bit is 1. As a result, every output-enable is low and every drive output is zero.
- R3: File addresses 5, 6 and 7 select ports A, B and C. Addresses 8 to 31 select general registers. Addresses 0 to 4 read as zero and ignore writes.
- R4: In file operations, bit [5] is the destination: 1 writes the result to the file register and leaves the accumulator unchanged, 0 writes it to the accumulator and leaves the file register unchanged.
- R5: The file operations behave as follows. Opcode 1 passes f. Opcode 2 gives f+1. Opcode 3 gives f+acc modulo 256. Opcode 4 gives f AND acc. Opcode 5 exchanges the nibbles of f. Opcode 6 clears f. Opcode 7 stores acc into f. Opcode 10 loads literal [7:0] into acc. Opcode 0 with sub-field [7:5]=1 clears acc, and sub-field 0 does nothing. The opcode is in [11:8] and f is in [4:0].
- R6: Opcode 8 skips the next instruction when bit [7:5] of f is 0, and opcode 9 skips it when that bit is 1. A skipped instruction has no effect, even if it is itself a skip or a control transfer.
- R7: Opcode 0 with sub-field [7:5]=2 copies acc into the direction register of the port at file address [4:0]. A direction bit of 1 makes the pin an input (output-enable low), and 0 makes it an output (output-enable high).
- R8: Reading a port returns the pin value for input bits and the latch value for output bits. Port A is 4 bits wide and reads with its upper four bits as zero. Ports B and C are 8 bits wide.
- R9: Opcode 12 jumps to [7:0]. Opcode 13 calls [7:0] and saves the return address in a single-entry stack, so a call made while the entry is in use overwrites it. Opcode 11 loads [7:0] into acc and returns to the saved address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | output | 8 | Program ROM address |
| prog_data | input | 12 | Program ROM word at prog_addr |
| io0_pin_i | input | 4 | Port A pin levels |
| io0_drv_o | output | 4 | Port A output latch |
| io0_oe_o | output | 4 | Port A output-enable per pin |
| io1_pin_i | input | 8 | Port B pin levels |
| io1_drv_o | output | 8 | Port B output latch |
| io1_oe_o | output | 8 | Port B output-enable per pin |
| io2_pin_i | input | 8 | Port C pin levels |
| io2_drv_o | output | 8 | Port C output latch |
| io2_oe_o | output | 8 | Port C output-enable per pin |

## Verification
The hardest situation to reach from the ports is an overwrite of the one-entry return stack by a nested call. Its result is only visible if the program reaches a point where the old and new return paths produce different port values. The program ROM in the bench calls a routine that calls a second routine. The first routine then runs code that only exists at the overwritten return address before jumping back, so a design that kept the outer return address writes a different value to port B. A skip that lands on another skip is reached in the same way, with a program in which the skipped skip would have hidden a literal load that shows on port B.

// File: rtl/mcu8_pkg.sv
package mcu8_pkg;
  localparam int DW     = 8;   // data width
  localparam int IW     = 12;  // instruction width
  localparam int AW     = 8;   // program address width
  localparam int FAW    = 5;   // file address width
  localparam int PAW    = 4;   // port A width
  localparam int GP_BASE = 8;
  localparam int GP_NUM  = (1 << FAW) - GP_BASE;
  localparam int PORT_BASE = 5;
  localparam int HW     = DW / 2;

  typedef enum logic [3:0] {
    OP_MISC    = 4'd0,
    OP_LOADF   = 4'd1,
    OP_INC     = 4'd2,
    OP_ADD     = 4'd3,
    OP_AND     = 4'd4,
    OP_SWAP    = 4'd5,
    OP_ZEROF   = 4'd6,
    OP_STORE   = 4'd7,
    OP_SKIPCLR = 4'd8,
    OP_SKIPSET = 4'd9,
    OP_LIT     = 4'd10,
    OP_RETLIT  = 4'd11,
    OP_JUMP    = 4'd12,
    OP_CALL    = 4'd13
  } opcode_e;

  localparam logic [2:0] SUB_NOP    = 3'd0;
  localparam logic [2:0] SUB_ZEROA  = 3'd1;
  localparam logic [2:0] SUB_DIRLD  = 3'd2;
endpackage

// File: rtl/mcu8_gpr.sv
module mcu8_gpr
  import mcu8_pkg::*;
(
  input  logic           clk,
  input  logic           we,
  input  logic [FAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [FAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  localparam logic [FAW-1:0] BASE = FAW'(GP_BASE);

  logic [DW-1:0] mem_q [GP_NUM];
  logic [FAW-1:0] widx;
  logic [FAW-1:0] ridx;

  always_comb begin
    widx  = waddr - BASE;
    ridx  = raddr - BASE;
    rdata = (raddr >= BASE) ? mem_q[ridx] : '0;
  end

  // storage array has no reset; software writes before it reads
  always_ff @(posedge clk) begin
    if (we && (waddr >= BASE)) begin
      mem_q[widx] <= wdata;
    end
  end
endmodule

// File: rtl/mcu8_port.sv
module mcu8_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lat_we,
  input  logic         dir_we,
  input  logic [W-1:0] dat_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] drv_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] dir_q, dir_d;

  always_comb begin
    lat_d = lat_we ? dat_i : lat_q;
    dir_d = dir_we ? dat_i : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      lat_q <= lat_d;
      dir_q <= dir_d;
    end
  end

  assign drv_o = lat_q;
  assign oe_o  = ~dir_q;
  assign rd_o  = (pin_i & dir_q) | (lat_q & ~dir_q);
endmodule

// File: rtl/mcu8_exec.sv
module mcu8_exec
  import mcu8_pkg::*;
(
  input  logic           ir_valid,
  input  logic [IW-1:0]  ir,
  input  logic [DW-1:0]  acc,
  input  logic [DW-1:0]  frd,
  input  logic [AW-1:0]  ret_addr,
  output logic [FAW-1:0] f_addr,
  output logic           f_we,
  output logic [DW-1:0]  f_wd,
  output logic           acc_we,
  output logic [DW-1:0]  acc_wd,
  output logic           dir_we,
  output logic           xfer,
  output logic [AW-1:0]  target,
  output logic           push,
  output logic           squash
);
  opcode_e       op;
  logic          dst_file;
  logic [2:0]    sub;
  logic [DW-1:0] lit;
  logic [DW-1:0] res;
  logic          alu_op;
  logic          skip;

  always_comb begin
    op       = opcode_e'(ir[11:8]);
    sub      = ir[7:5];
    dst_file = ir[5];
    lit      = ir[7:0];
    f_addr   = ir[FAW-1:0];
    res      = frd;
    alu_op   = 1'b0;
    f_we     = 1'b0;
    f_wd     = '0;
    acc_we   = 1'b0;
    acc_wd   = '0;
    dir_we   = 1'b0;
    xfer     = 1'b0;
    target   = lit;
    push     = 1'b0;
    skip     = 1'b0;
    if (ir_valid) begin
      case (op)
        OP_MISC: begin
          if (sub == SUB_ZEROA) begin
            acc_we = 1'b1;
          end else if (sub == SUB_DIRLD) begin
            dir_we = 1'b1;
          end
        end
        OP_LOADF: begin alu_op = 1'b1; res = frd; end
        OP_INC:   begin alu_op = 1'b1; res = frd + 1'b1; end
        OP_ADD:   begin alu_op = 1'b1; res = frd + acc; end
        OP_AND:   begin alu_op = 1'b1; res = frd & acc; end
        OP_SWAP:  begin alu_op = 1'b1; res = {frd[HW-1:0], frd[DW-1:HW]}; end
        OP_ZEROF: begin f_we = 1'b1; f_wd = '0; end
        OP_STORE: begin f_we = 1'b1; f_wd = acc; end
        OP_SKIPCLR: skip = ~frd[sub];
        OP_SKIPSET: skip = frd[sub];
        OP_LIT: begin acc_we = 1'b1; acc_wd = lit; end
        OP_RETLIT: begin
          acc_we = 1'b1;
          acc_wd = lit;
          xfer   = 1'b1;
          target = ret_addr;
        end
        OP_JUMP: xfer = 1'b1;
        OP_CALL: begin xfer = 1'b1; push = 1'b1; end
        default: ;
      endcase
      if (alu_op) begin
        if (dst_file) begin
          f_we = 1'b1;
          f_wd = res;
        end else begin
          acc_we = 1'b1;
          acc_wd = res;
        end
      end
    end
    squash = skip | xfer;
  end
endmodule

// File: rtl/mcu8_core.sv
module mcu8_core
  import mcu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  output logic [AW-1:0]  prog_addr,
  input  logic [IW-1:0]  prog_data,
  input  logic [PAW-1:0] io0_pin_i,
  output logic [PAW-1:0] io0_drv_o,
  output logic [PAW-1:0] io0_oe_o,
  input  logic [DW-1:0]  io1_pin_i,
  output logic [DW-1:0]  io1_drv_o,
  output logic [DW-1:0]  io1_oe_o,
  input  logic [DW-1:0]  io2_pin_i,
  output logic [DW-1:0]  io2_drv_o,
  output logic [DW-1:0]  io2_oe_o
);
  localparam int NWIDE = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // fetch and architectural state
  logic [AW-1:0] pc_q, pc_d;
  logic [IW-1:0] ir_q, ir_d;
  logic          irv_q, irv_d;
  logic [DW-1:0] acc_q, acc_d;
  logic [AW-1:0] stk_q, stk_d;

  // execute outputs
  logic [FAW-1:0] f_addr;
  logic           f_we;
  logic [DW-1:0]  f_wd;
  logic           acc_we;
  logic [DW-1:0]  acc_wd;
  logic           dir_we;
  logic           xfer;
  logic [AW-1:0]  target;
  logic           push;
  logic           squash;
  logic [DW-1:0]  frd;
  logic [DW-1:0]  gpr_rd;
  logic [DW-1:0]  port_dat;

  mcu8_exec u_exec (
    .ir_valid (irv_q),
    .ir       (ir_q),
    .acc      (acc_q),
    .frd      (frd),
    .ret_addr (stk_q),
    .f_addr   (f_addr),
    .f_we     (f_we),
    .f_wd     (f_wd),
    .acc_we   (acc_we),
    .acc_wd   (acc_wd),
    .dir_we   (dir_we),
    .xfer     (xfer),
    .target   (target),
    .push     (push),
    .squash   (squash)
  );

  always_comb begin
    pc_d  = xfer ? target : pc_q + 1'b1;
    ir_d  = prog_data;
    irv_d = ~squash;
    acc_d = acc_we ? acc_wd : acc_q;
    stk_d = push ? pc_q : stk_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      irv_q <= 1'b0;
      acc_q <= '0;
      stk_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      irv_q <= irv_d;
      acc_q <= acc_d;
      stk_q <= stk_d;
    end
  end

  assign prog_addr = pc_q;
  assign port_dat  = dir_we ? acc_q : f_wd;

  mcu8_gpr u_gpr (
    .clk   (clk),
    .we    (f_we),
    .waddr (f_addr),
    .wdata (f_wd),
    .raddr (f_addr),
    .rdata (gpr_rd)
  );

  // port A (narrow)
  logic [PAW-1:0] pa_rd;
  logic           pa_sel;
  assign pa_sel = (f_addr == FAW'(PORT_BASE));

  mcu8_port #(.W(PAW)) u_port_a (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .lat_we (f_we & pa_sel),
    .dir_we (dir_we & pa_sel),
    .dat_i  (port_dat[PAW-1:0]),
    .pin_i  (io0_pin_i),
    .drv_o  (io0_drv_o),
    .oe_o   (io0_oe_o),
    .rd_o   (pa_rd)
  );

  // ports B and C (full width)
  logic [NWIDE-1:0][DW-1:0] wpin, wdrv, woe, wrd;
  assign wpin = {io2_pin_i, io1_pin_i};

  for (genvar k = 0; k < NWIDE; k++) begin : g_wide
    logic sel;
    assign sel = (f_addr == FAW'(PORT_BASE + 1 + k));
    mcu8_port #(.W(DW)) u_port (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .lat_we (f_we & sel),
      .dir_we (dir_we & sel),
      .dat_i  (port_dat),
      .pin_i  (wpin[k]),
      .drv_o  (wdrv[k]),
      .oe_o   (woe[k]),
      .rd_o   (wrd[k])
    );
  end

  assign io1_drv_o = wdrv[0];
  assign io1_oe_o  = woe[0];
  assign io2_drv_o = wdrv[1];
  assign io2_oe_o  = woe[1];

  // file read multiplexer
  always_comb begin
    if (f_addr >= FAW'(GP_BASE))
      frd = gpr_rd;
    else if (pa_sel)
      frd = {{(DW-PAW){1'b0}}, pa_rd};
    else if (f_addr == FAW'(PORT_BASE + 1))
      frd = wrd[0];
    else if (f_addr == FAW'(PORT_BASE + 2))
      frd = wrd[1];
    else
      frd = '0;
  end
endmodule

// File: rtl/mcu8_core_chk.sv
module mcu8_core_chk
  import mcu8_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          irv,
  input logic [IW-1:0] ir,
  input logic [DW-1:0] acc,
  input logic [AW-1:0] prog_addr,
  input logic [AW-1:0] stk,
  input logic [DW-1:0] oe_b
);
  logic [3:0] op;
  logic       is_xfer;
  logic       is_fileop;
  logic       is_dirld_b;
  assign op         = ir[11:8];
  assign is_xfer    = irv && (op == 4'd11 || op == 4'd12 || op == 4'd13);
  assign is_fileop  = irv && (op >= 4'd1 && op <= 4'd5);
  assign is_dirld_b = irv && (op == 4'd0) && (ir[7:5] == 3'd2) && (ir[4:0] == 5'd6);

  assert_xfer_squash_R1: assert property (@(posedge clk) disable iff (!rst_n)
    is_xfer |=> !irv);

  assert_seq_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !is_xfer |=> prog_addr == $past(prog_addr) + 8'd1);

  assert_dest_file_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fileop && ir[5]) |=> $stable(acc));

  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_dirld_b |=> $stable(oe_b));

  assert_call_saves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irv && op == 4'd13) |=> stk == $past(prog_addr));
endmodule

bind mcu8_core mcu8_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .irv       (irv_q),
  .ir        (ir_q),
  .acc       (acc_q),
  .prog_addr (prog_addr),
  .stk       (stk_q),
  .oe_b      (io1_oe_o)
);

// File: tb/mcu8_core_tb_top.sv
`timescale 1ns/1ps
module mcu8_core_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  prog_addr;
  logic [11:0] prog_data;
  logic [3:0]  io0_pin, io0_drv, io0_oe;
  logic [7:0]  io1_pin, io1_drv, io1_oe;
  logic [7:0]  io2_pin, io2_drv, io2_oe;

  logic [11:0] rom [256];
  int          wp;
  int          n_checks;
  int          n_errors;
  bit          mon_on;

  typedef struct {
    logic [7:0] drv;
    logic [7:0] oe;
    string      req;
  } ev_t;
  ev_t exp_q[$];

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  assign prog_data = rom[prog_addr];

  mcu8_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .io0_pin_i (io0_pin),
    .io0_drv_o (io0_drv),
    .io0_oe_o  (io0_oe),
    .io1_pin_i (io1_pin),
    .io1_drv_o (io1_drv),
    .io1_oe_o  (io1_oe),
    .io2_pin_i (io2_pin),
    .io2_drv_o (io2_drv),
    .io2_oe_o  (io2_oe)
  );

  // encoders (layout from R5..R9)
  function automatic logic [11:0] enc_f(input logic [3:0] op, input logic d, input logic [4:0] f);
    return {op, 2'b00, d, f};
  endfunction
  function automatic logic [11:0] enc_b(input logic [3:0] op, input logic [2:0] b, input logic [4:0] f);
    return {op, b, f};
  endfunction
  function automatic logic [11:0] enc_k(input logic [3:0] op, input logic [7:0] k);
    return {op, k};
  endfunction

  task automatic emit(input logic [11:0] w);
    rom[wp] = w;
    wp++;
  endtask

  task automatic push_exp(input logic [7:0] drv, input logic [7:0] oe, input string req);
    ev_t e;
    e.drv = drv; e.oe = oe; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: every change on port B drive/enable pops one expected item
  initial begin
    logic [15:0] prev;
    prev = 16'h0000;
    forever begin
      @(negedge clk);
      if (mon_on && ({io1_drv, io1_oe} != prev)) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected port B change", {io1_drv, io1_oe}, prev);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check({io1_drv, io1_oe} == {e.drv, e.oe}, e.req, {io1_drv, io1_oe}, {e.drv, e.oe});
        end
        prev = {io1_drv, io1_oe};
      end
    end
  end

  initial begin
    int ret_here;
    int cyc;
    n_checks = 0;
    n_errors = 0;
    mon_on   = 1'b0;
    rst_n    = 1'b0;
    io0_pin  = 4'h3;
    io1_pin  = 8'hA5;
    io2_pin  = 8'h00;
    for (int i = 0; i < 256; i++) rom[i] = 12'h000;
    wp = 0;

    // R7: port B all output
    emit(enc_k(4'd10, 8'h00)); emit(enc_b(4'd0, 3'd2, 5'd6));
    push_exp(8'h00, 8'hFF, "R7 dir load to outputs");
    // R3: store to port B
    emit(enc_k(4'd10, 8'h3C)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h3C, 8'hFF, "R3 store to port B");
    // R5 swap into acc
    emit(enc_f(4'd7, 1'b0, 5'd8)); emit(enc_f(4'd5, 1'b0, 5'd8)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'hC3, 8'hFF, "R5 nibble swap");
    // R4 inc to file keeps acc C3; add wraps C3+3D=00
    emit(enc_f(4'd2, 1'b1, 5'd8)); emit(enc_f(4'd3, 1'b0, 5'd8)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h00, 8'hFF, "R4 destination select and add wrap");
    // R5 AND to file 3D&0F=0D
    emit(enc_k(4'd10, 8'h0F)); emit(enc_f(4'd4, 1'b1, 5'd8));
    emit(enc_f(4'd1, 1'b0, 5'd8)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h0D, 8'hFF, "R5 AND to file");
    // R7 partial direction
    emit(enc_k(4'd10, 8'hF0)); emit(enc_b(4'd0, 3'd2, 5'd6));
    push_exp(8'h0D, 8'h0F, "R7 partial direction");
    // R8 mixed read: (A5&F0)|(0D&0F)=AD
    emit(enc_f(4'd1, 1'b0, 5'd6)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'hAD, 8'h0F, "R8 mixed pin/latch read");
    emit(enc_k(4'd10, 8'h00)); emit(enc_b(4'd0, 3'd2, 5'd6));
    push_exp(8'hAD, 8'hFF, "R7 back to outputs");
    // R6 skip-if-clear taken (r8=0D bit1=0)
    emit(enc_b(4'd8, 3'd1, 5'd8)); emit(enc_k(4'd10, 8'h77)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h00, 8'hFF, "R6 skip if clear taken");
    // R6 skip-if-set taken (bit0=1)
    emit(enc_k(4'd10, 8'h44)); emit(enc_b(4'd9, 3'd0, 5'd8));
    emit(enc_k(4'd10, 8'h55)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h44, 8'hFF, "R6 skip if set taken");
    // R6 skip-if-clear not taken
    emit(enc_b(4'd8, 3'd0, 5'd8)); emit(enc_k(4'd10, 8'h99)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h99, 8'hFF, "R6 skip not taken");
    // R6 skipped skip has no effect
    emit(enc_b(4'd9, 3'd0, 5'd8)); emit(enc_b(4'd9, 3'd2, 5'd8));
    emit(enc_k(4'd10, 8'h12)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h12, 8'hFF, "R6 skipped skip ignored");
    // R9 call and literal return
    emit(enc_k(4'd13, 8'h80)); emit(enc_f(4'd7, 1'b0, 5'd6));
    rom[8'h80] = enc_k(4'd11, 8'h5A);
    push_exp(8'h5A, 8'hFF, "R9 call/return literal");
    // R9 nested call overwrites the single stack entry
    emit(enc_k(4'd13, 8'h90));
    ret_here = wp;
    emit(enc_f(4'd7, 1'b0, 5'd6));
    rom[8'h90] = enc_k(4'd13, 8'hA0);
    rom[8'h91] = enc_k(4'd10, 8'h3E);
    rom[8'h92] = enc_k(4'd12, 8'(ret_here));
    rom[8'hA0] = enc_k(4'd11, 8'h7C);
    push_exp(8'h3E, 8'hFF, "R9 stack overwrite");
    // R5 clear file
    emit(enc_f(4'd6, 1'b0, 5'd6));
    push_exp(8'h00, 8'hFF, "R5 clear file");
    // R5 clear acc
    emit(enc_k(4'd10, 8'h81)); emit(enc_f(4'd7, 1'b0, 5'd8));
    emit(enc_b(4'd0, 3'd1, 5'd0)); emit(enc_f(4'd3, 1'b0, 5'd8)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h81, 8'hFF, "R5 clear acc");
    // R3 unmapped address reads zero, write ignored
    emit(enc_f(4'd7, 1'b0, 5'd2)); emit(enc_f(4'd1, 1'b0, 5'd2)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h00, 8'hFF, "R3 unmapped address");
    // R8 narrow port A read
    emit(enc_k(4'd10, 8'h00)); emit(enc_b(4'd0, 3'd2, 5'd5));
    emit(enc_k(4'd10, 8'hFE)); emit(enc_f(4'd7, 1'b0, 5'd5));
    emit(enc_f(4'd1, 1'b0, 5'd5)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'h0E, 8'hFF, "R8 port A upper bits zero");
    // R3 top general register
    emit(enc_k(4'd10, 8'hB7)); emit(enc_f(4'd7, 1'b0, 5'd31));
    emit(enc_b(4'd0, 3'd1, 5'd0)); emit(enc_f(4'd1, 1'b0, 5'd31)); emit(enc_f(4'd7, 1'b0, 5'd6));
    push_exp(8'hB7, 8'hFF, "R3 general register 31");
    emit(enc_k(4'd12, 8'(wp)));

    // R2 reset state
    repeat (3) @(negedge clk);
    check(prog_addr == 8'h00, "R2 reset pc", {8'h0, prog_addr}, 16'h0);
    check({io0_drv, io0_oe} == 8'h00, "R2 reset port A", {8'h0, io0_drv, io0_oe}, 16'h0);
    check({io1_drv, io1_oe} == 16'h0, "R2 reset port B", {io1_drv, io1_oe}, 16'h0);
    check({io2_drv, io2_oe} == 16'h0, "R2 reset port C", {io2_drv, io2_oe}, 16'h0);

    mon_on = 1'b1;
    rst_n  = 1'b1;
    // R1: two sync stages then sequential fetch
    repeat (3) @(negedge clk);
    check(prog_addr == 8'h01, "R1 sequential fetch", {8'h0, prog_addr}, 16'h0001);

    cyc = 0;
    while (exp_q.size() != 0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    if (exp_q.size() != 0) begin
      check(1'b0, "watchdog expired", 16'(exp_q.size()), 16'h0);
    end
    repeat (10) @(negedge clk);
    check({io0_drv, io0_oe} == 8'hEF, "R7 R8 port A latch and enables",
          {8'h0, io0_drv, io0_oe}, 16'h00EF);
    check(io2_oe == 8'h00, "R7 port C untouched", {8'h0, io2_oe}, 16'h0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule